// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel that works through a list of transfer descriptors kept in memory. Software places descriptors in memory, writes the address of the first one into the channel, and sets the enable bit. The channel then reads each descriptor as six 32-bit words over a single word-wide memory port. It copies the descriptor's byte count from the source address to the destination address, one beat at a time. When the count runs out it follows the descriptor's link word to the next one, and stops when the link word holds the end marker.

Each descriptor carries a configuration word with a source half and a destination half. Each half selects a beat width of 1, 2 or 4 bytes and chooses whether its address steps forward or stays fixed. The burst code and request id are kept for readback but do not change how beats are issued. A ready input from the peripheral side gates the copy beats. A pause bit stalls all memory traffic, and a stop write abandons the work in hand. While the channel runs, its live configuration, addresses, remaining count and parameter word can be read back. Three single-cycle pulses report progress: half-way, descriptor done and list done.

The sequencer has seven named states. IDLE waits for a start. FETCH reads the six descriptor words, and its LOADED transition goes to DECIDE once the last word is in. DECIDE goes to PKG when the count is zero and to RD otherwise. RD reads one source word on a ready beat, and its CAPTURE transition goes to WR. WR writes one destination beat; its STEP transition returns to RD while bytes remain, and its DRAINED transition goes to PKG. PKG pulses descriptor-done, then takes LINK back to FETCH or ENDMARK to QDONE. QDONE pulses list-done and RETIRE returns to IDLE. A stop write from any state takes the ABORT transition to IDLE.

Top module: `llch_dma`

## Requirements
- R1: A descriptor is six 32-bit words at increasing word addresses starting at the descriptor address: cfg, src, dst, len, para, link. After the fetch, register words 3..7 (byte offsets 0x0C, 0x10, 0x14, 0x18, 0x1C) read back cfg, the current source address, the current destination address, the remaining count and para. Para is only stored.
- R2: A link value of 0xFFFFF800 ends the list. The channel pulses `irq_queue` for one cycle and returns to idle with no further memory requests. Any other link value is the address of the next descriptor, which is fetched next.
- R3: Writing a value with bit 0 set to offset 0x00 while the channel is idle starts it at the address held at offset 0x08. Offset 0x00 bit 0 reads 1 while the channel is active and 0 when it is idle.
- R4: Writing a value with bit 0 clear to offset 0x00 stops the channel at once. The remaining count reads 0 from the next cycle, no further memory request is made, and no completion pulse follows.
- R5: While bit 1 of offset 0x04 is set, no memory request is issued and the count holds. Clearing the bit resumes the transfer from the same point, and the transfer completes with correct data.
- R6: The width code sits at cfg bits [10:9] for the source and [26:25] for the destination, with 0, 1 and 2 meaning 1, 2 and 4 bytes per beat. Memory addresses are word aligned. The byte lanes read and written follow the low two address bits, and write strobes cover only the beat's bytes.
- R7: With the mode flag clear (cfg bit 5 for the source, bit 21 for the destination), the address advances by the beat width after each beat. With the flag set, the address stays fixed.
- R8: When the remaining count reaches zero, `irq_pkg` pulses for one cycle before the next descriptor fetch or the list end. A descriptor with length zero makes no data beats and still pulses `irq_pkg`.
- R9: `irq_half` pulses exactly once per descriptor: the cycle after the beat that first brings the remaining count to at most half of len.
- R10: With `drq_ready` low the channel still fetches descriptors, but it issues no copy beats. The count holds until `drq_ready` returns high.
- R11: After reset every register word reads 0 and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| drq_ready | input | 1 | Peripheral side ready; gates copy beats |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Memory byte write strobes |
| mem_ack | input | 1 | Memory accepts the request in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| irq_half | output | 1 | Half-way pulse |
| irq_pkg | output | 1 | Descriptor-done pulse |
| irq_queue | output | 1 | List-done pulse |

## Verification
With memory acknowledging every cycle, the list-done pulse falls exactly 8 + 2·beats cycles after the start write, summed over all descriptors in the list. The half-way pulse of a descriptor falls 7 + 2·j cycles after its start, where j is the beat that crosses half of len. The bench counts clock edges from the edge that registers the start write and samples one time unit after each edge. It compares the pulse cycles against these sums rather than waiting loosely. Register reads are combinational, so the pause, stop and ready-hold effects are checked on the cycles after the controlling edge, while the sequencer is held.

// File: rtl/llch_pkg.sv
package llch_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned DESC_WORDS = 6;
    localparam int unsigned WIDX_W     = $clog2(DESC_WORDS);
    localparam logic [DATA_W-1:0] LINK_END = 32'hFFFF_F800;

    // descriptor word positions, in fetch order
    localparam logic [WIDX_W-1:0] W_CFG  = 3'd0;
    localparam logic [WIDX_W-1:0] W_SRC  = 3'd1;
    localparam logic [WIDX_W-1:0] W_DST  = 3'd2;
    localparam logic [WIDX_W-1:0] W_LEN  = 3'd3;
    localparam logic [WIDX_W-1:0] W_PARA = 3'd4;
    localparam logic [WIDX_W-1:0] W_LINK = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECIDE, ST_RD, ST_WR, ST_PKG, ST_QDONE
    } llch_state_e;

    function automatic logic [2:0] beat_bytes(input logic [1:0] wcode);
        unique case (wcode)
            2'd0:    beat_bytes = 3'd1;
            2'd1:    beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/llch_lane.sv
module llch_lane (
    input  logic [31:0] rd_word,
    input  logic [1:0]  src_lo,
    input  logic [31:0] held,
    input  logic [1:0]  dst_lo,
    input  logic [1:0]  dst_wcode,
    output logic [31:0] aligned,
    output logic [31:0] placed,
    output logic [3:0]  strobe
);
    logic [3:0] mask;

    always_comb begin
        aligned = rd_word >> {src_lo, 3'b000};
        placed  = held << {dst_lo, 3'b000};
        unique case (dst_wcode)
            2'd0:    mask = 4'b0001;
            2'd1:    mask = 4'b0011;
            default: mask = 4'b1111;
        endcase
        strobe = mask << dst_lo;
    end
endmodule

// File: rtl/llch_regbank.sv
module llch_regbank #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy,
    input  logic [31:0]      cur_cfg,
    input  logic [31:0]      cur_src,
    input  logic [31:0]      cur_dst,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic [31:0]      cur_para,
    output logic             start_req,
    output logic             stop_req,
    output logic             pause_q,
    output logic [31:0]      head_q
);
    logic [2:0] word;
    logic       aligned_acc;

    assign word        = reg_addr[4:2];
    assign aligned_acc = (reg_addr[1:0] == 2'b00);
    assign start_req   = reg_we && aligned_acc && (word == 3'd0) && reg_wdata[0] && !busy;
    assign stop_req    = reg_we && aligned_acc && (word == 3'd0) && !reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pause_q <= 1'b0;
            head_q  <= '0;
        end else if (reg_we && aligned_acc) begin
            if (word == 3'd1) pause_q <= reg_wdata[1];
            if (word == 3'd2) head_q  <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned_acc) begin
            unique case (word)
                3'd0: reg_rdata = {31'b0, busy};
                3'd1: reg_rdata = {30'b0, pause_q, 1'b0};
                3'd2: reg_rdata = head_q;
                3'd3: reg_rdata = cur_cfg;
                3'd4: reg_rdata = cur_src;
                3'd5: reg_rdata = cur_dst;
                3'd6: reg_rdata = {{(32-CNT_W){1'b0}}, cur_cnt};
                default: reg_rdata = cur_para;
            endcase
        end
    end
endmodule

// File: rtl/llch_seq.sv
module llch_seq
    import llch_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             pause,
    input  logic [31:0]      head,
    input  logic             drq_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_wstrb,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             irq_half,
    output logic             irq_pkg,
    output logic             irq_queue,
    output logic             busy,
    output logic [31:0]      cur_cfg,
    output logic [31:0]      cur_src,
    output logic [31:0]      cur_dst,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [31:0]      cur_para
);
    llch_state_e        state_q;
    logic [WIDX_W-1:0]  widx_q;
    logic [31:0]        ptr_q, link_q, hold_q;
    logic [CNT_W-1:0]   len_q, cnt_nx, step;
    logic               half_q, xfer;
    logic [31:0]        aligned, placed;
    logic [3:0]         strobe;

    llch_lane lane_i (
        .rd_word  (mem_rdata),
        .src_lo   (cur_src[1:0]),
        .held     (hold_q),
        .dst_lo   (cur_dst[1:0]),
        .dst_wcode(cur_cfg[26:25]),
        .aligned  (aligned),
        .placed   (placed),
        .strobe   (strobe)
    );

    assign xfer   = mem_req && mem_ack;
    assign step   = {{(CNT_W-3){1'b0}}, beat_bytes(cur_cfg[26:25])};
    assign cnt_nx = (cur_cnt > step) ? (cur_cnt - step) : '0;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            widx_q   <= '0;
            ptr_q    <= '0;
            link_q   <= '0;
            hold_q   <= '0;
            len_q    <= '0;
            half_q   <= 1'b0;
            cur_cfg  <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
            cur_cnt  <= '0;
            cur_para <= '0;
        end else begin
            half_q <= 1'b0;
            if (stop_req) begin
                state_q <= ST_IDLE;
                cur_cnt <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: if (start_req) begin
                        ptr_q   <= head;
                        widx_q  <= '0;
                        state_q <= ST_FETCH;
                    end
                    ST_FETCH: if (xfer) begin
                        unique case (widx_q)
                            W_CFG:  cur_cfg  <= mem_rdata;
                            W_SRC:  cur_src  <= mem_rdata;
                            W_DST:  cur_dst  <= mem_rdata;
                            W_LEN: begin
                                len_q   <= mem_rdata[CNT_W-1:0];
                                cur_cnt <= mem_rdata[CNT_W-1:0];
                            end
                            W_PARA: cur_para <= mem_rdata;
                            default: link_q  <= mem_rdata;
                        endcase
                        if (widx_q == W_LINK) state_q <= ST_DECIDE;
                        else                  widx_q  <= widx_q + 1'b1;
                    end
                    ST_DECIDE: state_q <= (cur_cnt == '0) ? ST_PKG : ST_RD;
                    ST_RD: if (xfer) begin
                        hold_q  <= aligned;
                        state_q <= ST_WR;
                    end
                    ST_WR: if (xfer) begin
                        if (!cur_cfg[5])  cur_src <= cur_src + 32'(beat_bytes(cur_cfg[10:9]));
                        if (!cur_cfg[21]) cur_dst <= cur_dst + 32'(beat_bytes(cur_cfg[26:25]));
                        cur_cnt <= cnt_nx;
                        if ((cur_cnt > (len_q >> 1)) && (cnt_nx <= (len_q >> 1))) half_q <= 1'b1;
                        state_q <= (cnt_nx == '0) ? ST_PKG : ST_RD;
                    end
                    ST_PKG: begin
                        if (link_q == LINK_END) state_q <= ST_QDONE;
                        else begin
                            ptr_q   <= link_q;
                            widx_q  <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wstrb = '0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req  = !pause;
                mem_addr = ptr_q + {27'b0, widx_q, 2'b00};
            end
            ST_RD: begin
                mem_req  = !pause && drq_ready;
                mem_addr = {cur_src[31:2], 2'b00};
            end
            ST_WR: begin
                mem_req   = !pause && drq_ready;
                mem_we    = 1'b1;
                mem_addr  = {cur_dst[31:2], 2'b00};
                mem_wdata = placed;
                mem_wstrb = strobe;
            end
            default: ;
        endcase
        irq_half  = half_q;
        irq_pkg   = (state_q == ST_PKG);
        irq_queue = (state_q == ST_QDONE);
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/llch_dma.sv
module llch_dma #(
    parameter int unsigned CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        drq_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_wstrb,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        irq_half,
    output logic        irq_pkg,
    output logic        irq_queue
);
    logic             start_w, stop_w, pause_w, busy_w;
    logic [31:0]      head_w, cfg_w, src_w, dst_w, para_w;
    logic [CNT_W-1:0] cnt_w;

    llch_regbank #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy_w), .cur_cfg(cfg_w), .cur_src(src_w), .cur_dst(dst_w),
        .cur_cnt(cnt_w), .cur_para(para_w),
        .start_req(start_w), .stop_req(stop_w), .pause_q(pause_w), .head_q(head_w)
    );

    llch_seq #(.CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_w), .stop_req(stop_w), .pause(pause_w), .head(head_w),
        .drq_ready(drq_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_half(irq_half), .irq_pkg(irq_pkg), .irq_queue(irq_queue),
        .busy(busy_w), .cur_cfg(cfg_w), .cur_src(src_w), .cur_dst(dst_w),
        .cur_cnt(cnt_w), .cur_para(para_w)
    );
endmodule

// File: rtl/llch_dma_chk.sv
module llch_dma_chk #(
    parameter int unsigned CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [4:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             mem_req,
    input logic             mem_we,
    input logic [3:0]       mem_wstrb,
    input logic             irq_half,
    input logic             irq_pkg,
    input logic             irq_queue,
    input logic             pause_q,
    input logic             busy,
    input logic [CNT_W-1:0] cur_cnt
);
    logic stop_wr;
    assign stop_wr = reg_we && (reg_addr == 5'd0) && !reg_wdata[0];

    AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        pause_q |-> !mem_req);  // R5
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (!mem_req && cur_cnt == '0 && !irq_pkg && !irq_queue));  // R4
    AST_QUEUE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_queue |=> (!busy && !mem_req));  // R2
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_pkg, irq_queue}));  // R8
    AST_STROBE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wstrb != 4'b0000));  // R6
    AST_HALF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_half |=> !irq_half);  // R9
endmodule

bind llch_dma llch_dma_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wstrb(mem_wstrb),
    .irq_half(irq_half), .irq_pkg(irq_pkg), .irq_queue(irq_queue),
    .pause_q(pause_w), .busy(busy_w), .cur_cnt(cnt_w)
);

// File: tb/llch_dma_tb_top.sv
module llch_dma_tb_top;
    localparam int CLK_P = 10;
    localparam logic [31:0] END_LINK = 32'hFFFF_F800;
    localparam logic [31:0] CFG_W4 = 32'h0400_0400;
    localparam logic [31:0] CFG_W2 = 32'h0200_0200;
    localparam logic [31:0] CFG_W1 = 32'h0000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic drq_ready = 1'b1;
    logic mem_req, mem_we, mem_ack, irq_half, irq_pkg, irq_queue;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0] mem_wstrb;
    logic [31:0] mem [0:255];
    int checks = 0, fails = 0;
    bit done = 0;
    int qk, npkg, nhalf, khalf;

    always #(CLK_P/2) clk = ~clk;

    assign mem_ack   = 1'b1;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack)
            for (int b = 0; b < 4; b++)
                if (mem_wstrb[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end

    llch_dma dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .drq_ready(drq_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wstrb(mem_wstrb), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_half(irq_half), .irq_pkg(irq_pkg), .irq_queue(irq_queue)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return mem[a[9:2]][a[1:0]*8 +: 8];
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] cfg, src, dst, len, para, link);
        mem[base[9:2]]   = cfg;  mem[base[9:2]+1] = src;  mem[base[9:2]+2] = dst;
        mem[base[9:2]+3] = len;  mem[base[9:2]+4] = para; mem[base[9:2]+5] = link;
    endtask

    task automatic start_at(input logic [31:0] head);
        wr(5'h08, head);
        wr(5'h00, 32'h1);
    endtask

    task automatic wait_queue();
        qk = 0; npkg = 0; nhalf = 0; khalf = 0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            qk++;
            if (irq_half) begin nhalf++; khalf = qk; end
            if (irq_pkg) npkg++;
            if (irq_queue) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int w = 0; w < 8; w++) begin
            rd(5'(w*4), v);
            chk("R11 register reads zero after reset", v, 32'h0);
        end
        chk("R11 no request after reset", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_linear_word();
        logic [31:0] v;
        put_desc(32'h000, CFG_W4, 32'h100, 32'h200, 32'd16, 32'h8, END_LINK);
        start_at(32'h000);
        wait_queue();
        chk("R2 R8 queue pulse cycle, 4 beats", qk, 32'd16);
        chk("R8 one descriptor-done pulse", npkg, 32'd1);
        chk("R9 one half pulse", nhalf, 32'd1);
        chk("R9 half pulse cycle", khalf, 32'd11);
        for (int i = 0; i < 4; i++) chk("R6 R7 word copied", mem[128+i], mem[64+i]);
        @(posedge clk); #1;
        rd(5'h00, v); chk("R3 enable reads idle after list end", v, 32'h0);
        rd(5'h18, v); chk("R8 count drained", v, 32'h0);
    endtask

    task automatic t_chain();
        put_desc(32'h020, CFG_W1, 32'h111, 32'h213, 32'd3, 32'h0, 32'h040);
        put_desc(32'h040, CFG_W2, 32'h120, 32'h222, 32'd4, 32'h0, END_LINK);
        start_at(32'h020);
        wait_queue();
        chk("R2 chained queue pulse cycle", qk, 32'd26);
        chk("R2 R8 two descriptor-done pulses", npkg, 32'd2);
        for (int i = 0; i < 3; i++)
            chk("R6 byte lane copy", {24'b0, mbyte(32'h213 + i)}, {24'b0, mbyte(32'h111 + i)});
        for (int i = 0; i < 4; i++)
            chk("R6 halfword copy", {24'b0, mbyte(32'h222 + i)}, {24'b0, mbyte(32'h120 + i)});
        chk("R6 strobe kept neighbour byte", {24'b0, mbyte(32'h212)}, 32'h0);
        chk("R6 strobe kept byte after halfwords", {24'b0, mbyte(32'h226)}, 32'h0);
    endtask

    task automatic t_zero_len();
        mem[32'h260 >> 2] = 32'hDEAD_BEEF;
        put_desc(32'h060, CFG_W4, 32'h100, 32'h260, 32'd0, 32'h0, END_LINK);
        start_at(32'h060);
        wait_queue();
        chk("R8 zero length queue cycle", qk, 32'd8);
        chk("R8 zero length pkg pulse", npkg, 32'd1);
        chk("R9 zero length no half", nhalf, 32'd0);
        chk("R8 zero length no write", mem[32'h260 >> 2], 32'hDEAD_BEEF);
    endtask

    task automatic t_io_mode();
        logic [31:0] v;
        mem[32'h140 >> 2] = 32'hA1B2_C3D4;
        put_desc(32'h080, CFG_W4 | 32'h20, 32'h140, 32'h240, 32'd8, 32'h0, END_LINK);
        start_at(32'h080);
        wait_queue();
        chk("R7 fixed source queue cycle", qk, 32'd12);
        chk("R7 fixed source word0", mem[32'h240 >> 2], 32'hA1B2_C3D4);
        chk("R7 fixed source word1", mem[32'h244 >> 2], 32'hA1B2_C3D4);
        rd(5'h10, v); chk("R7 source address unchanged", v, 32'h140);
        rd(5'h14, v); chk("R7 destination advanced", v, 32'h248);
    endtask

    task automatic t_ready_hold();
        logic [31:0] v;
        drq_ready = 1'b0;
        put_desc(32'h0A0, CFG_W4, 32'h100, 32'h280, 32'd8, 32'h5A5A_0003, END_LINK);
        start_at(32'h0A0);
        repeat (20) @(posedge clk);
        #1;
        chk("R10 no beat while not ready", {31'b0, mem_req}, 32'h0);
        rd(5'h00, v); chk("R3 enable reads active", v, 32'h1);
        rd(5'h0C, v); chk("R1 cfg readback", v, CFG_W4);
        rd(5'h10, v); chk("R1 src readback", v, 32'h100);
        rd(5'h14, v); chk("R1 dst readback", v, 32'h280);
        rd(5'h18, v); chk("R10 count held at len", v, 32'd8);
        rd(5'h1C, v); chk("R1 para readback", v, 32'h5A5A_0003);
        @(negedge clk); drq_ready = 1'b1;
        wait_queue();
        chk("R10 completes after ready", npkg, 32'd1);
        chk("R10 data word0", mem[32'h280 >> 2], mem[64]);
        chk("R10 data word1", mem[32'h284 >> 2], mem[65]);
    endtask

    task automatic t_pause();
        logic [31:0] v, c0;
        put_desc(32'h0C0, CFG_W1, 32'h100, 32'h2A0, 32'd16, 32'h0, END_LINK);
        start_at(32'h0C0);
        repeat (10) @(posedge clk);
        wr(5'h04, 32'h2);
        rd(5'h04, v); chk("R5 pause bit reads set", v, 32'h2);
        rd(5'h18, c0);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            chk("R5 no request while paused", {31'b0, mem_req}, 32'h0);
        end
        rd(5'h18, v); chk("R5 count holds while paused", v, c0);
        wr(5'h04, 32'h0);
        wait_queue();
        chk("R5 resumed to one completion", npkg, 32'd1);
        for (int i = 0; i < 16; i++)
            chk("R5 resumed data", {24'b0, mbyte(32'h2A0 + i)}, {24'b0, mbyte(32'h100 + i)});
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int seen = 0;
        for (int i = 0; i < 4; i++) mem[(32'h2C0 >> 2) + i] = 32'h0;
        put_desc(32'h0E0, CFG_W1, 32'h100, 32'h2C0, 32'd16, 32'h0, END_LINK);
        start_at(32'h0E0);
        repeat (13) @(posedge clk);
        wr(5'h00, 32'h0);
        rd(5'h18, v); chk("R4 count cleared by stop", v, 32'h0);
        rd(5'h00, v); chk("R4 enable reads idle after stop", v, 32'h0);
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            if (mem_req || irq_pkg || irq_queue) seen++;
        end
        chk("R4 no activity after stop", seen, 32'd0);
        chk("R4 tail byte never written", {24'b0, mbyte(32'h2CF)}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 0; i < 32; i++) mem[64 + i] = 32'h1020_3040 + i * 32'h0405_0607;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1 t_reset();
        t_linear_word();
        t_chain();
        t_zero_len();
        t_io_mode();
        t_ready_hold();
        t_pause();
        t_stop();
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule